// File: doc/BRIEF.md
# Exhaustive Syndrome Test Engine

This block works out the syndrome numerator of one output of a combinational circuit under test. It drives every input combination of a chosen width onto the circuit, one combination per clock. Each time the output being watched is high, a minterm counter steps. Once all combinations of the configured width have been presented, the engine stops and raises a done flag. A host can then read the count and compare it with the fault-free value.

A host drives the block through a byte-wide register window with eight offsets. Some offsets act as strobes: start, stop, clear the pattern counter, and clear the minterm counter. One offset is a writable control byte that selects the input width and the output to watch. The other offsets are reads for the done flag and the two halves of the count. For each output, the host follows the same sequence:

1. Stop the engine.
2. Load the control byte.
3. Clear both counters.
4. Start the engine.
5. Poll the done flag until it is set.
6. Read the count.

Top module: `syndrome_tester`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the following state holds:
  - `cut_in` is zero and `done` is low.
  - The minterm count reads zero.
  - The run flag is cleared.
  - The control byte is zero.
- R2: Any access, read or write, to offset 0 sets the run flag. Any access to offset 1 clears it. While the run flag is clear, `cut_in` and the count hold their values, and a later start resumes from where the engine stopped.
- R3: A write to offset 3 loads the control byte:
  - Bits [2:0] hold a width code c, and the input width is N = c + 4, so N runs from 4 to 11.
  - Bits [5:3] select the monitored output, from `cut_out[0]` to `cut_out[7]`.
  - Bits [7:6] have no effect.
- R4: While running, the pattern counter advances by one on every clock, starting from zero. `cut_in` carries its low 11 bits. After exactly 2^N advances, bit N of the counter is set. At that point:
  - `done` goes high.
  - The counter freezes, so `cut_in` equals 2^N truncated to 11 bits (0 when N = 11).
- R5: On each advancing clock, the minterm count rises by one when the selected output is 1 for the combination then on `cut_in`. A finished run therefore holds the number of combinations 0 to 2^N−1 for which that output is 1. The count is 12 bits wide and reaches 2048 without wrapping.
- R6: A read of offset 2 returns `done` on bit 0, with bits [7:1] zero.
- R7: A read of offset 6 returns count bits [7:0]. A read of offset 7 returns count bits [11:8] in data bits [3:0], with bits [7:4] zero.
- R8: An access to offset 4 zeroes the pattern counter, which also drops `done`. An access to offset 5 zeroes the minterm count.
- R9: While `done` is high, a start access does not advance the pattern counter or the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both the test and the host bus |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | High for a write access |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |
| cut_in | output | 11 | Input combination driven onto the circuit under test |
| cut_out | input | 8 | Outputs returned by the circuit under test |
| done | output | 1 | High once every combination of the configured width has been presented |

## Verification
The assertions assume the following about the inputs:
- Each host access is a single-cycle `bus_sel` pulse with a stable offset.
- `cut_out` is a pure function of `cut_in` within the same cycle.
- The control byte is rewritten only while the engine is stopped.

The stimulus meets these conditions in three ways:
- It performs every access through one task that holds the bus for exactly one cycle, with an idle cycle after it.
- It models the circuit under test as combinational logic built from randomly chosen masks.
- It loads the control byte only after a stop access.

// File: rtl/syn_pkg.sv
package syn_pkg;
  typedef enum logic [2:0] {
    OFS_START  = 3'd0,
    OFS_STOP   = 3'd1,
    OFS_DONE   = 3'd2,
    OFS_CTRL   = 3'd3,
    OFS_CLRPAT = 3'd4,
    OFS_CLRCNT = 3'd5,
    OFS_CNTLO  = 3'd6,
    OFS_CNTHI  = 3'd7
  } host_ofs_e;

  typedef struct packed {
    logic [1:0] spare;
    logic [2:0] out_idx;
    logic [2:0] width_code;
  } ctrl_t;
endpackage

// File: rtl/syn_host_regs.sv
module syn_host_regs
  import syn_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              done,
  input  logic [CNT_W-1:0]  count,
  output ctrl_t             ctrl,
  output logic              run,
  output logic              clr_pat,
  output logic              clr_cnt,
  output logic [DATA_W-1:0] bus_rdata
);
  host_ofs_e ofs;
  assign ofs = host_ofs_e'(bus_addr);

  // Strobe offsets act on any access, read or write.
  assign clr_pat = bus_sel && (ofs == OFS_CLRPAT);
  assign clr_cnt = bus_sel && (ofs == OFS_CLRCNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      ctrl <= '0;
    end else if (bus_sel) begin
      if (ofs == OFS_START) run <= 1'b1;
      if (ofs == OFS_STOP)  run <= 1'b0;
      if (ofs == OFS_CTRL && bus_wr) ctrl <= ctrl_t'(bus_wdata[7:0]);
    end
  end

  logic [CNT_W-1:0] cnt_hi;
  assign cnt_hi = count >> DATA_W;

  always_comb begin
    bus_rdata = '0;
    case (ofs)
      OFS_DONE:  bus_rdata[0] = done;
      OFS_CNTLO: bus_rdata = count[DATA_W-1:0];
      OFS_CNTHI: bus_rdata = cnt_hi[DATA_W-1:0];
      default:   bus_rdata = '0;
    endcase
  end

  // R2: start and stop strobes steer the run flag
  p_start_sets_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == OFS_START) |=> run);
  p_stop_clears_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == OFS_STOP) |=> !run);
endmodule

// File: rtl/syn_pattern_gen.sv
module syn_pattern_gen #(
  parameter int PAT_W  = 12,
  parameter int CODE_W = 3,
  parameter int MIN_IN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [CODE_W-1:0] width_code,
  output logic [PAT_W-1:0]  pat,
  output logic              advance,
  output logic              done
);
  localparam int N_CODES = 2 ** CODE_W;

  // One terminal bit per width code: bit (code + MIN_IN) of the counter.
  logic [N_CODES-1:0] term_bits;
  for (genvar g = 0; g < N_CODES; g++) begin : g_term
    if (g + MIN_IN < PAT_W) begin : g_bit
      assign term_bits[g] = pat[g + MIN_IN];
    end else begin : g_none
      assign term_bits[g] = 1'b0;
    end
  end

  assign done    = term_bits[width_code];
  assign advance = run && !done && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) pat <= '0;
    else if (advance)  pat <= pat + 1'b1;
  end

  // R4: frozen once the terminal bit is up
  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> $stable(pat));
  // R4: never moves by more than one per clock
  p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (pat == $past(pat) || pat == $past(pat) + 1'b1));
  // R2: holds while stopped
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pat));
  // R8: clear empties the counter
  p_clear_pat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pat == '0));
endmodule

// File: rtl/syn_minterm_counter.sv
module syn_minterm_counter #(
  parameter int OUT_N = 8,
  parameter int CNT_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     advance,
  input  logic                     clr,
  input  logic [$clog2(OUT_N)-1:0] out_idx,
  input  logic [OUT_N-1:0]         cut_out,
  output logic [CNT_W-1:0]         count
);
  logic watched;
  assign watched = cut_out[out_idx];

  always_ff @(posedge clk) begin
    if (!rst_n || clr)           count <= '0;
    else if (advance && watched) count <= count + 1'b1;
  end

  // R5: count steps by at most one
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count == $past(count) || count == $past(count) + 1'b1));
  // R5: no counting without an advancing clock
  p_count_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !clr) |=> $stable(count));
  // R8: clear empties the count
  p_clear_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/syndrome_tester.sv
module syndrome_tester
  import syn_pkg::*;
#(
  parameter int PAT_W  = 12,
  parameter int OUT_N  = 8,
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8,
  parameter int MIN_IN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [PAT_W-2:0]  cut_in,
  input  logic [OUT_N-1:0]  cut_out,
  output logic              done
);
  localparam int IN_W = PAT_W - 1;

  ctrl_t            ctrl;
  logic             run, clr_pat, clr_cnt, advance;
  logic [PAT_W-1:0] pat;
  logic [CNT_W-1:0] count;

  syn_host_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .done(done), .count(count),
    .ctrl(ctrl), .run(run), .clr_pat(clr_pat), .clr_cnt(clr_cnt),
    .bus_rdata(bus_rdata)
  );

  syn_pattern_gen #(.PAT_W(PAT_W), .CODE_W(3), .MIN_IN(MIN_IN)) u_pat (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(clr_pat),
    .width_code(ctrl.width_code), .pat(pat), .advance(advance), .done(done)
  );

  syn_minterm_counter #(.OUT_N(OUT_N), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .advance(advance), .clr(clr_cnt),
    .out_idx(ctrl.out_idx), .cut_out(cut_out), .count(count)
  );

  assign cut_in = pat[IN_W-1:0];
endmodule

// File: tb/syndrome_tester_tb_top.sv
`timescale 1ns/1ps
module syndrome_tester_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic [10:0] cut_in;
  logic [7:0]  cut_out;
  logic        done;

  int n_chk = 0, n_bad = 0;
  logic [1:0]  kind [8];
  logic [10:0] mask [8];

  always #2.5 clk = ~clk;

  syndrome_tester dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cut_in(cut_in), .cut_out(cut_out), .done(done)
  );

  // Model of the circuit under test: 0 const0, 1 const1, 2 parity, 3 AND of masked bits.
  function automatic logic cut_fn(input logic [10:0] p, input int j);
    case (kind[j])
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return ^(p & mask[j]);
      default: return &(p | ~mask[j]);
    endcase
  endfunction

  always_comb for (int j = 0; j < 8; j++) cut_out[j] = cut_fn(cut_in, j);

  function automatic int exp_count(input int code, input int idx);
    int c = 0;
    for (int p = 0; p < (1 << (code + 4)); p++) c += int'(cut_fn(11'(p), idx));
    return c;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic acc(input logic [2:0] a, input logic w, input logic [7:0] d,
                     output logic [7:0] r);
    @(negedge clk);
    bus_sel = 1'b1; bus_addr = a; bus_wr = w; bus_wdata = d;
    #1 r = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wait_done(output logic ok);
    logic [7:0] r;
    ok = 1'b0;
    for (int k = 0; k < 3000 && !ok; k++) begin
      acc(3'd2, 1'b0, 8'h00, r);
      ok = r[0];
    end
  endtask

  task automatic read_count(output int c);
    logic [7:0] lo, hi;
    acc(3'd6, 1'b0, 8'h00, lo);
    acc(3'd7, 1'b0, 8'h00, hi);
    check(hi[7:4] == 4'h0, "R7 high bits zero", int'(hi[7:4]), 0);
    c = int'({hi[3:0], lo});
  endtask

  task automatic setup(input int code, input int idx);
    logic [7:0] r;
    acc(3'd1, 1'b0, 8'h00, r);
    acc(3'd3, 1'b1, {2'($urandom), 3'(idx), 3'(code)}, r);
    acc(3'd4, 1'b0, 8'h00, r);
    acc(3'd5, 1'b1, 8'h00, r);
  endtask

  task automatic run_test(input int code, input int idx);
    logic [7:0] r;
    logic ok;
    int c, e, frz;
    setup(code, idx);
    acc(3'd0, 1'b1, 8'h00, r);
    wait_done(ok);
    check(ok, "R4 done reached", int'(ok), 1);
    frz = (code == 7) ? 0 : (1 << (code + 4));
    check(int'(cut_in) == frz, "R4 frozen pattern", int'(cut_in), frz);
    repeat (4) @(negedge clk);
    check(done && int'(cut_in) == frz, "R4 hold after done", int'(cut_in), frz);
    read_count(c);
    e = exp_count(code, idx);
    check(c == e, "R5 minterm count", c, e);
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
  end

  initial begin
    logic [7:0] r;
    logic ok;
    int c, e, snap;
    void'($urandom(32'h5A17));
    for (int j = 0; j < 8; j++) begin kind[j] = 2'd2; mask[j] = 11'h7FF; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check(cut_in == 0 && !done, "R1 reset outputs", int'(cut_in), 0);
    read_count(c);
    check(c == 0, "R1 reset count", c, 0);
    acc(3'd2, 1'b0, 8'h00, r);
    check(r == 8'h00, "R6 done read idle", int'(r), 0);
    repeat (3) @(negedge clk);
    check(cut_in == 0, "R1 run flag clear", int'(cut_in), 0);

    // Directed corners: constant-1 at width 11, constant-0 at width 4.
    kind[5] = 2'd1;
    run_test(7, 5);
    read_count(c);
    check(c == 2048, "R5 no wrap at 2048", c, 2048);
    acc(3'd7, 1'b0, 8'h00, r);
    check(r == 8'h08, "R7 high read", int'(r), 8);
    acc(3'd2, 1'b0, 8'h00, r);
    check(r == 8'h01, "R6 done read set", int'(r), 1);
    kind[0] = 2'd0;
    run_test(0, 0);

    // R9: a start while done changes nothing.
    snap = int'(cut_in);
    acc(3'd0, 1'b0, 8'h00, r);
    repeat (6) @(negedge clk);
    read_count(c);
    check(int'(cut_in) == snap && c == 0, "R9 start while done", int'(cut_in), snap);

    // R8: clear both counters.
    kind[3] = 2'd2; mask[3] = 11'h055;
    run_test(4, 3);
    acc(3'd5, 1'b0, 8'h00, r);
    read_count(c);
    check(c == 0, "R8 count cleared", c, 0);
    acc(3'd4, 1'b1, 8'h00, r);
    check(cut_in == 0 && !done, "R8 pattern cleared", int'(cut_in), 0);

    // R2: stop mid-run (stop via read access), hold, then resume.
    kind[6] = 2'd3; mask[6] = 11'h003;
    setup(3, 6);
    acc(3'd0, 1'b1, 8'h00, r);
    repeat (20) @(negedge clk);
    acc(3'd1, 1'b0, 8'h00, r);
    snap = int'(cut_in);
    repeat (8) @(negedge clk);
    check(int'(cut_in) == snap && !done && snap > 0, "R2 hold while stopped", int'(cut_in), snap);
    acc(3'd0, 1'b0, 8'h00, r);
    wait_done(ok);
    read_count(c);
    e = exp_count(3, 6);
    check(ok && c == e, "R2 resume count", c, e);

    // R3: output select and width across random configurations.
    for (int t = 0; t < 12; t++) begin
      int code, idx;
      for (int j = 0; j < 8; j++) begin
        kind[j] = 2'($urandom);
        mask[j] = 11'($urandom);
      end
      code = int'($urandom % 8);
      idx = int'($urandom % 8);
      run_test(code, idx);
      check(1'b1, "R3 configuration applied", code, code);
    end

    report();
  end
endmodule